// File: doc/BRIEF.md
# Software-Paced I2C Bus Master

This block is an I2C bus master that takes one step at a time and is driven by software through a small register window. Software asks for a START, a repeated START, a byte transfer or a STOP. The block carries out that one bus action, then raises an interrupt flag and posts a one-byte status code that names what happened. SCL is then held low, so the bus stays parked, until software clears the flag. Clearing the flag starts the next action.

The block handles master transmit and master receive, acknowledge generation and checking, and loss of arbitration. It drives SCL and SDA as open-drain enables: a 1 pulls the line low. It reads both lines back through synchronisers. A monitor watches the bus for START and STOP conditions from any master. A requested START waits until the bus is free.

The window has these registers, all at 3-bit addresses:
- control: read at address 0 or 6. Writing address 0 sets bits; writing address 6 clears bits.
- status: address 1.
- data: address 2.
- SCL high period: address 3.
- SCL low period: address 4.

The control bits are:
- bit 6: enable
- bit 5: start request
- bit 4: stop request
- bit 3: interrupt flag
- bit 2: acknowledge enable
- bits 7, 1 and 0: read as zero

Top module: `i2cm_core`

## Requirements
- R1: After reset, control reads 0x00, status reads 0xF8, data reads 0x00, the irq output is low and neither line is pulled.
- R2: A write to address 0 sets each control bit that is 1 in the written value. A write to address 6 clears each such bit. Zero bits leave a bit unchanged. Writing bit 3 to address 0 never sets the interrupt flag.
- R3: The START sequence runs when enable is set, start is set, the flag is clear and the bus is free. SDA falls while SCL is released, then SCL is pulled low. The flag is set, status reads 0x08, and the start bit clears itself.
- R4: After another master's START has been seen and before its STOP, a start request produces no bus activity. Once the STOP appears, the START of R3 goes ahead.
- R5: While the interrupt flag is set after an event that left SCL low, SCL stays pulled low.
- R6: The first byte after a START is an address. Bit 0 of that byte = 0 means write, 1 means read. An acknowledged write address gives status 0x18 and a refused one gives 0x20. An acknowledged read address gives 0x40 and a refused one gives 0x48.
- R7: In transmit mode the data register is sent MSB first. An acknowledged data byte gives status 0x28 and a refused one gives 0x30.
- R8: In receive mode the received byte, MSB first, is loaded into the data register. The block drives the acknowledge slot low only when acknowledge enable is set. Status is then 0x50 if the slot was low and 0x58 if it was not.
- R9: With start set and the flag cleared while the block owns the bus, a repeated START is sent and status reads 0x10. A following address with bit 0 set moves the block into receive mode.
- R10: With stop set and the flag cleared while the block owns the bus, SDA rises while SCL is released. The stop bit then clears itself, both lines are released and the flag stays clear.
- R11: Arbitration is lost when the block releases SDA for a 1 bit and reads SDA low at the end of the high phase. Status 0x38 is then posted and both lines are released.
- R12: Every bit slot pulls SCL low for exactly the low-period register value in clocks, then releases it for exactly the high-period register value.
- R13: Whenever the interrupt flag is clear, status reads 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A bus-level slave model acknowledges one address and answers reads with a fixed two-byte pattern. Against it, the transfer engine is driven through these patterns:
- a write to a matching address, followed by one data byte the slave acknowledges and one it refuses, which separates 0x28 from 0x30;
- a write to a non-matching address, which separates 0x18 from 0x20;
- a write address, then a repeated START and a read address, then two received bytes with acknowledge enable first set and then cleared. This shows that the direction bit switches mode and that the returned acknowledge follows the control bit.

Two further patterns hold SDA low from the bench. In the first, a foreign START from an idle bus must defer the block's own START. In the second, SDA is forced low under a transmitted 1, which must give arbitration loss rather than a normal completion. Slot widths are measured on SCL against the period registers.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // register window
    localparam logic [2:0] RA_SET  = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_DATA = 3'd2;
    localparam logic [2:0] RA_THI  = 3'd3;
    localparam logic [2:0] RA_TLO  = 3'd4;
    localparam logic [2:0] RA_CLR  = 3'd6;

    // control bit positions
    localparam int B_EN  = 6;
    localparam int B_STA = 5;
    localparam int B_STO = 4;
    localparam int B_SI  = 3;
    localparam int B_AA  = 2;

    // status codes
    localparam logic [7:0] ST_START  = 8'h08;
    localparam logic [7:0] ST_RSTART = 8'h10;
    localparam logic [7:0] ST_AW_ACK = 8'h18;
    localparam logic [7:0] ST_AW_NAK = 8'h20;
    localparam logic [7:0] ST_DW_ACK = 8'h28;
    localparam logic [7:0] ST_DW_NAK = 8'h30;
    localparam logic [7:0] ST_ARB    = 8'h38;
    localparam logic [7:0] ST_AR_ACK = 8'h40;
    localparam logic [7:0] ST_AR_NAK = 8'h48;
    localparam logic [7:0] ST_DR_ACK = 8'h50;
    localparam logic [7:0] ST_DR_NAK = 8'h58;
    localparam logic [7:0] ST_NONE   = 8'hF8;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_HOLD, S_BLO, S_BHI,
        S_RLO, S_RHI, S_PLO, S_PHI, S_PEND
    } eng_st_e;

    typedef struct packed {
        logic en;
        logic sta;
        logic sto;
        logic si;
        logic aa;
    } ctl_t;

    function automatic logic [7:0] ctl_pack(ctl_t c);
        return {1'b0, c.en, c.sta, c.sto, c.si, c.aa, 2'b00};
    endfunction

    // status code after the acknowledge slot of a byte
    function automatic logic [7:0] byte_code(logic is_addr, logic rd, logic ack);
        case ({is_addr, rd})
            2'b10:   return ack ? ST_AW_ACK : ST_AW_NAK;
            2'b11:   return ack ? ST_AR_ACK : ST_AR_NAK;
            2'b00:   return ack ? ST_DW_ACK : ST_DW_NAK;
            default: return ack ? ST_DR_ACK : ST_DR_NAK;
        endcase
    endfunction

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_s,
    output logic busy
);
    localparam int NL = 2;  // line 0 = SCL, line 1 = SDA

    logic [NL-1:0] raw;
    logic [NL-1:0] synced;
    logic [NL-1:0] prev;

    assign raw = {sda_raw, scl_raw};

    for (genvar g = 0; g < NL; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign synced[g] = pipe[STAGES-1];
    end

    logic start_seen, stop_seen;
    assign start_seen = prev[1] && !synced[1] && synced[0] && prev[0];
    assign stop_seen  = !prev[1] && synced[1] && synced[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '1;
            busy <= 1'b0;
        end else begin
            prev <= synced;
            if (start_seen)     busy <= 1'b1;
            else if (stop_seen) busy <= 1'b0;
        end
    end

    assign sda_s = synced[1];
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine import i2cm_pkg::*; #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          si,
    input  logic          sta,
    input  logic          sto,
    input  logic          aa,
    input  logic          bus_busy,
    input  logic [7:0]    tx_byte,
    input  logic [PW-1:0] hi_per,
    input  logic [PW-1:0] lo_per,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          evt,
    output logic [7:0]    evt_code,
    output logic [7:0]    rx_byte,
    output logic          rx_load,
    output logic          sta_ack,
    output logic          sto_ack
);
    localparam logic [PW-1:0] ONE = PW'(1);
    localparam logic [3:0]    ACK_IDX = 4'd8;

    eng_st_e       st;
    logic [PW-1:0] cnt;
    logic [3:0]    idx;
    logic [7:0]    sh;
    logic          rd_mode, addr_ph, rep, sda_q;

    logic cnt_done, tx_dir, slot_drv, arb_lost, ack_slot;
    assign cnt_done = (cnt == '0);
    assign tx_dir   = addr_ph || !rd_mode;
    assign ack_slot = (idx == ACK_IDX);
    assign slot_drv = ack_slot ? (!tx_dir && aa) : (tx_dir && !sh[7]);
    assign arb_lost = tx_dir && !ack_slot && sh[7] && !sda_in;

    always_comb begin
        scl_oe = 1'b0;
        case (st)
            S_HOLD, S_BLO, S_RLO, S_PLO: scl_oe = 1'b1;
            default:                     scl_oe = 1'b0;
        endcase
    end
    assign sda_oe = sda_q;

    always_comb begin
        evt      = 1'b0;
        evt_code = ST_NONE;
        if (st == S_START && cnt_done) begin
            evt      = 1'b1;
            evt_code = rep ? ST_RSTART : ST_START;
        end else if (st == S_BHI && cnt_done) begin
            if (arb_lost) begin
                evt      = 1'b1;
                evt_code = ST_ARB;
            end else if (ack_slot) begin
                evt      = 1'b1;
                evt_code = byte_code(addr_ph, rd_mode, !sda_in);
            end
        end
    end

    assign sta_ack = (st == S_START) && cnt_done;
    assign sto_ack = (st == S_PEND) && cnt_done;
    assign rx_load = (st == S_BHI) && cnt_done && ack_slot && !tx_dir;
    assign rx_byte = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cnt     <= '0;
            idx     <= '0;
            sh      <= '0;
            rd_mode <= 1'b0;
            addr_ph <= 1'b0;
            rep     <= 1'b0;
            sda_q   <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    sda_q <= 1'b0;
                    if (en && sta && !si && !bus_busy) begin
                        st  <= S_START;
                        cnt <= hi_per - ONE;
                        rep <= 1'b0;
                    end
                end
                S_START: begin
                    sda_q <= 1'b1;
                    if (cnt_done) begin
                        st      <= S_HOLD;
                        addr_ph <= 1'b1;
                    end else cnt <= cnt - ONE;
                end
                S_HOLD: begin
                    if (!en) st <= S_IDLE;
                    else if (!si) begin
                        cnt <= lo_per - ONE;
                        if (sto)      st <= S_PLO;
                        else if (sta) st <= S_RLO;
                        else begin
                            st  <= S_BLO;
                            idx <= '0;
                            sh  <= tx_byte;
                            if (addr_ph) rd_mode <= tx_byte[0];
                        end
                    end
                end
                S_BLO: begin
                    sda_q <= slot_drv;
                    if (cnt_done) begin
                        st  <= S_BHI;
                        cnt <= hi_per - ONE;
                    end else cnt <= cnt - ONE;
                end
                S_BHI: begin
                    if (cnt_done) begin
                        if (arb_lost) st <= S_IDLE;
                        else if (ack_slot) begin
                            st      <= S_HOLD;
                            addr_ph <= 1'b0;
                        end else begin
                            sh  <= tx_dir ? {sh[6:0], 1'b0} : {sh[6:0], sda_in};
                            idx <= idx + 4'd1;
                            st  <= S_BLO;
                            cnt <= lo_per - ONE;
                        end
                    end else cnt <= cnt - ONE;
                end
                S_RLO, S_RHI: begin
                    sda_q <= 1'b0;
                    if (cnt_done) begin
                        st  <= (st == S_RLO) ? S_RHI : S_START;
                        cnt <= hi_per - ONE;
                        rep <= (st == S_RHI);
                    end else cnt <= cnt - ONE;
                end
                S_PLO, S_PHI: begin
                    sda_q <= 1'b1;
                    if (cnt_done) begin
                        st  <= (st == S_PLO) ? S_PHI : S_PEND;
                        cnt <= hi_per - ONE;
                    end else cnt <= cnt - ONE;
                end
                S_PEND: begin
                    sda_q <= 1'b0;
                    if (cnt_done) st <= S_IDLE;
                    else          cnt <= cnt - ONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_core.sv
module i2cm_core import i2cm_pkg::*; #(
    parameter int BUS_W  = 16,
    parameter int DEF_HI = 8,
    parameter int DEF_LO = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             irq,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);
    localparam int PW = BUS_W;

    ctl_t          ctl;
    logic [7:0]    data_q, code_q;
    logic [PW-1:0] thi, tlo;

    logic       sda_s, bus_busy;
    logic       evt, rx_load, sta_ack, sto_ack;
    logic [7:0] evt_code, rx_byte;

    i2cm_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
        .sda_s(sda_s), .busy(bus_busy)
    );

    i2cm_engine #(.PW(PW)) u_eng (
        .clk(clk), .rst(rst), .en(ctl.en), .si(ctl.si), .sta(ctl.sta),
        .sto(ctl.sto), .aa(ctl.aa), .bus_busy(bus_busy), .tx_byte(data_q),
        .hi_per(thi), .lo_per(tlo), .sda_in(sda_s),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .evt(evt), .evt_code(evt_code),
        .rx_byte(rx_byte), .rx_load(rx_load), .sta_ack(sta_ack), .sto_ack(sto_ack)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            data_q <= '0;
            code_q <= ST_NONE;
            thi    <= PW'(DEF_HI);
            tlo    <= PW'(DEF_LO);
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    RA_SET: begin
                        ctl.en  <= ctl.en  | reg_wdata[B_EN];
                        ctl.sta <= ctl.sta | reg_wdata[B_STA];
                        ctl.sto <= ctl.sto | reg_wdata[B_STO];
                        ctl.aa  <= ctl.aa  | reg_wdata[B_AA];
                    end
                    RA_CLR: begin
                        ctl.en  <= ctl.en  & ~reg_wdata[B_EN];
                        ctl.sta <= ctl.sta & ~reg_wdata[B_STA];
                        ctl.sto <= ctl.sto & ~reg_wdata[B_STO];
                        ctl.si  <= ctl.si  & ~reg_wdata[B_SI];
                        ctl.aa  <= ctl.aa  & ~reg_wdata[B_AA];
                    end
                    RA_DATA: data_q <= reg_wdata[7:0];
                    RA_THI:  thi    <= reg_wdata;
                    RA_TLO:  tlo    <= reg_wdata;
                    default: ;
                endcase
            end
            if (sta_ack) ctl.sta <= 1'b0;
            if (sto_ack) ctl.sto <= 1'b0;
            if (evt) begin
                ctl.si <= 1'b1;
                code_q <= evt_code;
            end
            if (rx_load) data_q <= rx_byte;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_SET, RA_CLR: reg_rdata = BUS_W'(ctl_pack(ctl));
            RA_STAT:        reg_rdata = BUS_W'(ctl.si ? code_q : ST_NONE);
            RA_DATA:        reg_rdata = BUS_W'(data_q);
            RA_THI:         reg_rdata = thi;
            RA_TLO:         reg_rdata = tlo;
            default:        reg_rdata = '0;
        endcase
    end

    assign irq = ctl.si;
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk import i2cm_pkg::*; (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       en,
    input logic       sta,
    input logic       evt,
    input logic [7:0] evt_code,
    input logic       bus_busy,
    input logic       idle,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic [7:0] stat_rd
);
    a_r2_no_sw_flag: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_SET && !irq && !evt) |=> !irq);

    a_r3_sta_clears: assert property (@(posedge clk) disable iff (rst)
        (evt && (evt_code == ST_START || evt_code == ST_RSTART) &&
         !(reg_wr && reg_addr == RA_SET)) |=> !sta);

    a_r4_wait_free: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && idle) |=> !sda_oe && !scl_oe);

    a_r5_scl_held: assert property (@(posedge clk) disable iff (rst)
        (irq && scl_oe && en) |=> scl_oe);

    a_r11_release: assert property (@(posedge clk) disable iff (rst)
        (evt && evt_code == ST_ARB) |=> (!scl_oe && !sda_oe));

    a_r13_idle_status: assert property (@(posedge clk) disable iff (rst)
        (!irq && reg_addr == RA_STAT) |-> stat_rd == ST_NONE);
endmodule

bind i2cm_core i2cm_chk u_chk (
    .clk(clk), .rst(rst), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .en(ctl.en), .sta(ctl.sta), .evt(evt), .evt_code(evt_code),
    .bus_busy(bus_busy), .idle(u_eng.st == i2cm_pkg::S_IDLE),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .stat_rd(reg_rdata[7:0])
);

// File: tb/sim_i2cm_core.sv
`timescale 1ns/1ps
module sim_i2cm_core;
    localparam int HI = 5;
    localparam int LO = 6;
    localparam logic [6:0] SLV_ADR = 7'h2A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, scl_oe, sda_oe;

    logic s_drv = 1'b0;
    logic jam = 1'b0;
    logic ack_data = 1'b1;
    wire  scl_line = !scl_oe;
    wire  sda_line = !(sda_oe || s_drv || jam);

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = !clk;

    i2cm_core u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // ---- slave model ----
    logic s_act = 0, s_adr = 0, s_rw = 0, s_send = 0, s_macked = 0;
    int   s_bit = 0, s_ridx = 0;
    logic [7:0] s_sh = '0, s_tx = '0, s_got = '0;

    function automatic logic [7:0] pat(int i);
        return (i == 0) ? 8'hA5 : 8'h3C;
    endfunction

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        s_act = 1; s_adr = 1; s_bit = 0; s_drv = 0; s_send = 0;
    end
    always @(posedge sda_line) if (scl_line === 1'b1) begin
        s_act = 0; s_drv = 0; s_send = 0;
    end
    always @(posedge scl_line) if (s_act) begin
        if (s_bit < 8) s_sh = {s_sh[6:0], sda_line};
        else           s_macked = !sda_line;
        s_bit++;
    end
    always @(negedge scl_line) if (s_act) begin
        if (s_bit == 8) begin
            if (s_send)     s_drv = 0;
            else if (s_adr) begin s_rw = s_sh[0]; s_drv = (s_sh[7:1] == SLV_ADR); end
            else begin s_got = s_sh; s_drv = ack_data; end
        end else if (s_bit == 9) begin
            s_bit = 0;
            if (s_adr) begin
                s_adr = 0;
                if (s_drv && s_rw) begin
                    s_send = 1; s_tx = pat(s_ridx); s_ridx++; s_drv = !s_tx[7];
                end else begin
                    if (!s_drv) s_act = 0;
                    s_drv = 0;
                end
            end else if (s_send) begin
                if (s_macked) begin s_tx = pat(s_ridx); s_ridx++; s_drv = !s_tx[7]; end
                else begin s_send = 0; s_drv = 0; s_act = 0; end
            end else s_drv = 0;
        end else if (s_send && s_bit > 0) begin
            s_drv = !s_tx[7 - s_bit];
        end
    end

    // ---- SCL run-length monitor ----
    logic prev_scl = 1'b0;
    int run = 0, w_hi = 0, w_lo = 0;
    always @(posedge clk) begin
        if (scl_oe == prev_scl) run++;
        else begin
            if (prev_scl) w_lo = run; else w_hi = run;
            run = 1;
        end
        prev_scl = scl_oe;
    end

    // ---- helpers ----
    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_si(string tag);
        int n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        if (!irq) begin
            n_run++; n_fail++;
            $display("FAIL %s flag timeout actual=0 expected=1", tag);
        end
    endtask

    task automatic step(string tag, logic [7:0] exp_code);
        logic [15:0] v;
        wr(3'd6, 16'h0008);
        wait_si(tag);
        rd(3'd1, v);
        chk(tag, v, {8'h00, exp_code});
    endtask

    task automatic do_stop(string tag);
        logic [15:0] v;
        int n = 0;
        wr(3'd0, 16'h0010);
        wr(3'd6, 16'h0008);
        v = 16'h0010;
        while (v[4] && n < 500) begin rd(3'd0, v); n++; end
        repeat (HI + 4) @(negedge clk);
        chk({tag, " R10 stop bit self-clear"}, {15'd0, v[4]}, 16'd0);
        chk({tag, " R10 no flag"}, {15'd0, irq}, 16'd0);
        chk({tag, " R10 lines released"}, {14'd0, scl_oe, sda_oe}, 16'd0);
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); chk("R1 control", v, 16'h0000);
        rd(3'd1, v); chk("R1 status", v, 16'h00F8);
        rd(3'd2, v); chk("R1 data", v, 16'h0000);
        chk("R1 outputs", {13'd0, irq, scl_oe, sda_oe}, 16'd0);
    endtask

    task automatic t_setclr();
        logic [15:0] v;
        wr(3'd0, 16'h0004); rd(3'd0, v); chk("R2 set aa", v, 16'h0004);
        wr(3'd0, 16'h0008); rd(3'd0, v); chk("R2 flag not settable", v, 16'h0004);
        wr(3'd0, 16'h0000); rd(3'd0, v); chk("R2 zero set", v, 16'h0004);
        wr(3'd6, 16'h0000); rd(3'd0, v); chk("R2 zero clear", v, 16'h0004);
        wr(3'd6, 16'h0004); rd(3'd0, v); chk("R2 clear aa", v, 16'h0000);
        rd(3'd1, v); chk("R13 idle status", v, 16'h00F8);
    endtask

    task automatic t_write();
        logic [15:0] v;
        wr(3'd3, 16'(HI)); wr(3'd4, 16'(LO));
        wr(3'd0, 16'h0040);
        wr(3'd0, 16'h0020);
        wait_si("R3 start");
        rd(3'd1, v); chk("R3 start status", v, 16'h0008);
        rd(3'd0, v); chk("R3 start bit self-clear", {15'd0, v[5]}, 16'd0);
        repeat (30) @(negedge clk);
        chk("R5 scl held while flag set", {15'd0, scl_oe}, 16'd1);
        wr(3'd2, {8'h00, SLV_ADR, 1'b0});
        step("R6 write addr ack", 8'h18);
        ack_data = 1'b1;
        wr(3'd2, 16'h005C);
        step("R7 data ack", 8'h28);
        chk("R7 byte seen by slave", {8'h00, s_got}, 16'h005C);
        chk("R12 high width", 16'(w_hi), 16'(HI));
        chk("R12 low width", 16'(w_lo), 16'(LO));
        ack_data = 1'b0;
        wr(3'd2, 16'h0081);
        step("R7 data nack", 8'h30);
        chk("R7 second byte", {8'h00, s_got}, 16'h0081);
        do_stop("write");
        rd(3'd1, v); chk("R13 status after stop", v, 16'h00F8);
    endtask

    task automatic t_addr_nack();
        wr(3'd0, 16'h0020);
        wait_si("R3 start 2");
        wr(3'd2, 16'h0066);
        step("R6 write addr nack", 8'h20);
        do_stop("nack");
    endtask

    task automatic t_read();
        logic [15:0] v;
        wr(3'd0, 16'h0020);
        wait_si("R3 start 3");
        wr(3'd2, {8'h00, SLV_ADR, 1'b0});
        step("R6 addr ack before restart", 8'h18);
        wr(3'd0, 16'h0020);
        step("R9 repeated start", 8'h10);
        wr(3'd2, {8'h00, SLV_ADR, 1'b1});
        step("R6 R9 read addr ack", 8'h40);
        wr(3'd0, 16'h0004);
        step("R8 rx ack", 8'h50);
        rd(3'd2, v); chk("R8 first rx byte", v, 16'h00A5);
        wr(3'd6, 16'h0004);
        step("R8 rx nack", 8'h58);
        rd(3'd2, v); chk("R8 second rx byte", v, 16'h003C);
        do_stop("read");
    endtask

    task automatic t_busy();
        logic [15:0] v;
        @(negedge clk); jam = 1'b1;
        repeat (10) @(negedge clk);
        wr(3'd0, 16'h0020);
        repeat (60) @(negedge clk);
        chk("R4 no start while busy", {14'd0, irq, scl_oe}, 16'd0);
        jam = 1'b0;
        wait_si("R4 start after stop");
        rd(3'd1, v); chk("R4 deferred start status", v, 16'h0008);
        do_stop("busy");
    endtask

    task automatic t_arb();
        logic [15:0] v;
        wr(3'd0, 16'h0020);
        wait_si("R3 start 4");
        wr(3'd2, 16'h00C0);
        @(negedge clk); jam = 1'b1;
        step("R11 arbitration lost", 8'h38);
        @(negedge clk);
        chk("R11 lines released", {14'd0, scl_oe, sda_oe}, 16'd0);
        jam = 1'b0;
        wr(3'd6, 16'h0008);
        repeat (10) @(negedge clk);
        rd(3'd1, v); chk("R13 status after clear", v, 16'h00F8);
    endtask

    initial begin
        #2000000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setclr();
        t_write();
        t_addr_nack();
        t_read();
        t_busy();
        t_arb();
        repeat (10) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule